// File: doc/BRIEF.md
# Multi-core interrupt distributor

The block sits between a bank of shared interrupt sources and the request inputs of a small group of cores. Every source has its own slot of state: a destination mode, a trigger mode, a mask of the cores it may reach, a sticky pending bit, a per-core acknowledge record, a delivery flag and a round-robin pointer. A slot that has pending work and a non-empty target mask starts a delivery, and the delivery raises the request line of one, some or all of the target cores.

Software runs everything through two registers. A 16-bit command word carries the source number and an opcode. A 32-bit parameter register holds the operand for a write command, and a read command leaves its result there. The command port also names the core that issues the command, so that an acknowledge can be credited to that core. A global enable gates every core request line. Capture of pending work goes on while the enable is off.

Top module: `irq_distributor`

## Requirements
- R1: After reset the unit is globally disabled and every `irq_o` bit is 0. Every slot has trigger mode level, destination mode 0, target mask 0, no pending work, no acknowledge and round-robin pointer 0, so mode, mask and status reads all return 0.
- R2: A command word has the source number in bits 15:8 and the opcode in bits 7:0. The opcodes are 0x00 global disable, 0x01 global enable, 0x02 clear, 0x03 software assert, 0x04 write mode, 0x05 read status, 0x06 acknowledge, 0x07 read pending, 0x08 read mode, 0x09 write mask and 0x0A read mask. Any other opcode changes no state and leaves `param_o` unchanged.
- R3: Write mode takes the trigger mode from parameter bit 15 (0 = level, 1 = pulse) and the destination mode from bits 7:0. Destination codes are 0 off, 1 round-robin, 2 first taker and 3 all targets. A code above 3 is stored as 0. Read mode returns the trigger mode in bit 15 and the destination code in bits 1:0, with every other bit 0.
- R4: Write mask stores parameter bits 3:0 as the target-core mask, where bit k stands for core k. Read mask returns those 4 bits, with bits 31:4 at 0.
- R5: In pulse mode with a destination code other than 0, a rising edge on the source sets a sticky pending bit. That bit stays set after the source falls. A clear command, or an acknowledge that takes effect, removes it. A clear also ends any delivery that is in progress and erases the acknowledge record. Read pending returns the pending state in bit 0.
- R6: In level mode the source line itself counts as pending while the destination code is not 0. The pending read follows the line.
- R7: Software assert sets the sticky pending bit in either trigger mode.
- R8: Read status returns bit 0 = destination code not 0, bit 1 = raw source level, bit 2 = some core has acknowledged, bit 3 = pending, and bits 9:8 = index of the next round-robin recipient. Every other bit is 0.
- R9: While the unit is globally disabled, every `irq_o` bit is 0, but pending work is still captured and deliveries still start. After global enable, the requests of any delivery in progress appear.
- R10: In round-robin mode a delivery raises only the request of the core at the next set mask bit after the previous recipient, wrapping around. The pointer moves only when a delivery starts.
- R11: In first-taker mode every target core is requested. The first acknowledge from a requested core withdraws the request from all cores. In level mode no new delivery starts until the source has gone low.
- R12: In all-targets mode each target core stays requested until that core acknowledges. An acknowledge from a core that is not being requested has no effect in any mode.
- R13: A command or source edge takes effect at the next rising clock edge, and a read result is on `param_o` after the edge that accepts the read. A delivery starts at the edge after pending is seen, so its requests appear at that edge. An acknowledge or clear withdraws the requests at the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_IRQ (256) | Shared interrupt source lines |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 16 | Command word: source number in bits 15:8, opcode in bits 7:0 |
| cmd_core_i | input | CW (2) | Index of the core issuing the command |
| param_we_i | input | 1 | Parameter register write strobe |
| param_i | input | 32 | Parameter write data |
| param_o | output | 32 | Parameter register contents (operand or read result) |
| irq_o | output | N_CORE (4) | Per-core interrupt request lines |

## Verification
The results fall due at three different points, and the bench samples each at its own point. Slot state and read results appear one edge after the command, so each command task returns on the falling edge after the accepting edge, and the bench samples `param_o` there. A software assert or a source edge in pulse mode reaches `irq_o` only after a second edge, because pending must be registered before a delivery starts. The bench waits one extra cycle after an assert and two after a raw source edge. An acknowledge, a clear or a global disable drops the request at the accepting edge itself. The bench then waits two more cycles for the delivery flag and the acknowledge record to clear before it starts the next round-robin round.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned CMD_W   = 16;
  localparam int unsigned PARAM_W = 32;

  typedef enum logic [7:0] {
    OP_GDIS  = 8'h00,
    OP_GEN   = 8'h01,
    OP_CLR   = 8'h02,
    OP_SET   = 8'h03,
    OP_WMODE = 8'h04,
    OP_STAT  = 8'h05,
    OP_ACK   = 8'h06,
    OP_PEND  = 8'h07,
    OP_RMODE = 8'h08,
    OP_WMASK = 8'h09,
    OP_RMASK = 8'h0A
  } op_e;

  typedef enum logic [1:0] {
    DM_OFF   = 2'd0,
    DM_RR    = 2'd1,
    DM_FIRST = 2'd2,
    DM_ALL   = 2'd3
  } dmode_e;

  typedef enum logic [1:0] {
    RK_STAT = 2'd0,
    RK_PEND = 2'd1,
    RK_MODE = 2'd2,
    RK_MASK = 2'd3
  } rkind_e;

  typedef struct packed {
    logic clr;
    logic set;
    logic wmode;
    logic ack;
    logic wmask;
  } slot_op_t;
endpackage

// File: rtl/irqd_cmd_dec.sv
module irqd_cmd_dec
  import irqd_pkg::*;
#(
  parameter int unsigned N_IRQ = 256,
  localparam int unsigned IW   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [N_IRQ-1:0]  sel_o,
  output logic [IW-1:0]     idx_o,
  output slot_op_t          op_o,
  output logic              gen_o,
  output logic              gdis_o,
  output logic              rd_o,
  output rkind_e            rkind_o
);
  logic [7:0] num;
  logic [7:0] opc;
  logic       hit;

  assign num   = cmd_i[15:8];
  assign opc   = cmd_i[7:0];
  assign hit   = cmd_we_i && (int'(num) < int'(N_IRQ));
  assign idx_o = IW'(num);
  assign sel_o = hit ? (N_IRQ'(1) << num) : '0;

  always_comb begin
    op_o    = '0;
    gen_o   = 1'b0;
    gdis_o  = 1'b0;
    rd_o    = 1'b0;
    rkind_o = RK_STAT;
    if (cmd_we_i) begin
      case (opc)
        OP_GDIS:  gdis_o    = 1'b1;
        OP_GEN:   gen_o     = 1'b1;
        OP_CLR:   op_o.clr  = 1'b1;
        OP_SET:   op_o.set  = 1'b1;
        OP_WMODE: op_o.wmode = 1'b1;
        OP_ACK:   op_o.ack  = 1'b1;
        OP_WMASK: op_o.wmask = 1'b1;
        OP_STAT:  begin rd_o = hit; rkind_o = RK_STAT; end
        OP_PEND:  begin rd_o = hit; rkind_o = RK_PEND; end
        OP_RMODE: begin rd_o = hit; rkind_o = RK_MODE; end
        OP_RMASK: begin rd_o = hit; rkind_o = RK_MASK; end
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/irqd_rr_next.sv
module irqd_rr_next #(
  parameter int unsigned N_CORE = 4,
  localparam int unsigned CW    = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
  input  logic [N_CORE-1:0] mask_i,
  input  logic [CW-1:0]     last_i,
  output logic [CW-1:0]     nxt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    nxt_o = last_i;
    for (int k = 1; k <= int'(N_CORE); k++) begin
      int j;
      j = (int'(last_i) + k) % int'(N_CORE);
      if (!found && mask_i[j]) begin
        nxt_o = CW'(j);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqd_slot.sv
module irqd_slot
  import irqd_pkg::*;
#(
  parameter int unsigned N_CORE = 4,
  localparam int unsigned CW    = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_i,
  input  logic              sel_i,
  input  slot_op_t          op_i,
  input  logic [CW-1:0]     core_i,
  input  logic              wtrig_i,
  input  logic [7:0]        wdest_i,
  input  logic [N_CORE-1:0] wmask_i,
  output logic [N_CORE-1:0] tgt_o,
  output logic              on_o,
  output logic              ack_o,
  output logic              pend_o,
  output logic [CW-1:0]     nxt_o,
  output logic              trig_o,
  output logic [1:0]        dest_o,
  output logic [N_CORE-1:0] mask_o
);
  logic              trig_q, pend_q, del_q, src_q;
  dmode_e            dmode_q;
  logic [N_CORE-1:0] mask_q, ackm_q, tgt_all, rr_hot;
  logic [CW-1:0]     last_q, nxt;
  logic              on, lvl_hit, edge_hit, pending, done, start, ack_ok;

  irqd_rr_next #(.N_CORE(N_CORE)) u_rr (
    .mask_i (mask_q),
    .last_i (last_q),
    .nxt_o  (nxt)
  );

  assign on       = (dmode_q != DM_OFF);
  assign lvl_hit  = !trig_q && on && src_i;
  assign edge_hit = trig_q && on && src_i && !src_q;
  assign pending  = pend_q || lvl_hit;
  assign tgt_all  = mask_q & ~ackm_q;
  assign rr_hot   = N_CORE'(1) << last_q;
  assign done     = (dmode_q == DM_ALL) ? (tgt_all == '0) : (ackm_q != '0);
  assign start    = !del_q && on && (mask_q != '0) && pending && (ackm_q == '0);

  always_comb begin
    tgt_o = '0;
    if (del_q && !done) begin
      unique case (dmode_q)
        DM_RR:             tgt_o = rr_hot;
        DM_FIRST, DM_ALL:  tgt_o = tgt_all;
        default:           tgt_o = '0;
      endcase
    end
  end

  assign ack_ok = sel_i && op_i.ack && tgt_o[core_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q  <= 1'b0;
      dmode_q <= DM_OFF;
      mask_q  <= '0;
      pend_q  <= 1'b0;
      del_q   <= 1'b0;
      ackm_q  <= '0;
      last_q  <= '0;
      src_q   <= 1'b0;
    end else begin
      src_q <= src_i;
      if (sel_i && op_i.wmode) begin
        trig_q  <= wtrig_i;
        dmode_q <= (wdest_i[7:2] != '0) ? DM_OFF : dmode_e'(wdest_i[1:0]);
      end
      if (sel_i && op_i.wmask) mask_q <= wmask_i;
      // delivery flag
      if (sel_i && op_i.clr)  del_q <= 1'b0;
      else if (del_q)         del_q <= !(done || !on);
      else                    del_q <= start;
      if (start && dmode_q == DM_RR) last_q <= nxt;
      // acknowledge record; held while a level source stays high
      if (sel_i && op_i.clr)             ackm_q <= '0;
      else if (ack_ok)                   ackm_q[core_i] <= 1'b1;
      else if (!del_q && !lvl_hit)       ackm_q <= '0;
      // sticky pending: set sources win over removal
      if ((sel_i && op_i.clr) || ack_ok) pend_q <= 1'b0;
      if ((sel_i && op_i.set) || edge_hit) pend_q <= 1'b1;
    end
  end

  assign on_o   = on;
  assign ack_o  = (ackm_q != '0);
  assign pend_o = pending;
  assign nxt_o  = nxt;
  assign trig_o = trig_q;
  assign dest_o = dmode_q;
  assign mask_o = mask_q;

  AST_PULSE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && on && src_i && !src_q) |=> pend_q) else $error("pulse edge lost"); // R5
  AST_CLEAR_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && op_i.clr) |=> (!del_q && ackm_q == '0)) else $error("clear left delivery"); // R5
  AST_RR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmode_q == DM_RR) |-> $onehot0(tgt_o)) else $error("rr multi target"); // R10
  AST_FIRST_WITHDRAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_ok && dmode_q == DM_FIRST) |=> (tgt_o == '0)) else $error("first taker not withdrawn"); // R11
  AST_ALL_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_ok && dmode_q == DM_ALL) |=> !tgt_o[$past(core_i)]) else $error("acked core still requested"); // R12
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int unsigned N_IRQ  = 256,
  parameter int unsigned N_CORE = 4,
  localparam int unsigned CW    = (N_CORE > 1) ? $clog2(N_CORE) : 1,
  localparam int unsigned IW    = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_IRQ-1:0]   src_i,
  input  logic               cmd_we_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic [CW-1:0]      cmd_core_i,
  input  logic               param_we_i,
  input  logic [PARAM_W-1:0] param_i,
  output logic [PARAM_W-1:0] param_o,
  output logic [N_CORE-1:0]  irq_o
);
  logic [N_IRQ-1:0]   sel;
  logic [IW-1:0]      idx;
  slot_op_t           op;
  logic               gen, gdis, rd;
  rkind_e             rkind;
  logic               en_q;
  logic [PARAM_W-1:0] param_q, rd_word;

  logic [N_CORE-1:0]  tgt_a  [N_IRQ];
  logic [N_CORE-1:0]  mask_a [N_IRQ];
  logic [CW-1:0]      nxt_a  [N_IRQ];
  logic [1:0]         dest_a [N_IRQ];
  logic [N_IRQ-1:0]   on_a, ack_a, pend_a, trig_a;

  irqd_cmd_dec #(.N_IRQ(N_IRQ)) u_dec (
    .cmd_we_i (cmd_we_i),
    .cmd_i    (cmd_i),
    .sel_o    (sel),
    .idx_o    (idx),
    .op_o     (op),
    .gen_o    (gen),
    .gdis_o   (gdis),
    .rd_o     (rd),
    .rkind_o  (rkind)
  );

  for (genvar g = 0; g < int'(N_IRQ); g++) begin : g_slot
    irqd_slot #(.N_CORE(N_CORE)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_i[g]),
      .sel_i   (sel[g]),
      .op_i    (op),
      .core_i  (cmd_core_i),
      .wtrig_i (param_q[15]),
      .wdest_i (param_q[7:0]),
      .wmask_i (param_q[N_CORE-1:0]),
      .tgt_o   (tgt_a[g]),
      .on_o    (on_a[g]),
      .ack_o   (ack_a[g]),
      .pend_o  (pend_a[g]),
      .nxt_o   (nxt_a[g]),
      .trig_o  (trig_a[g]),
      .dest_o  (dest_a[g]),
      .mask_o  (mask_a[g])
    );
  end

  always_comb begin
    rd_word = '0;
    unique case (rkind)
      RK_STAT: begin
        rd_word[0]      = on_a[idx];
        rd_word[1]      = src_i[idx];
        rd_word[2]      = ack_a[idx];
        rd_word[3]      = pend_a[idx];
        rd_word[8 +: CW] = nxt_a[idx];
      end
      RK_PEND: rd_word[0] = pend_a[idx];
      RK_MODE: begin
        rd_word[15]  = trig_a[idx];
        rd_word[1:0] = dest_a[idx];
      end
      RK_MASK: rd_word[N_CORE-1:0] = mask_a[idx];
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      param_q <= '0;
    end else begin
      if (gen)       en_q <= 1'b1;
      else if (gdis) en_q <= 1'b0;
      if (rd)              param_q <= rd_word;
      else if (param_we_i) param_q <= param_i;
    end
  end

  always_comb begin
    logic [N_CORE-1:0] acc;
    acc = '0;
    for (int i = 0; i < int'(N_IRQ); i++) acc |= tgt_a[i];
    irq_o = en_q ? acc : '0;
  end

  assign param_o = param_q;

  AST_GDIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[7:0] == OP_GDIS) |=> (irq_o == '0)) else $error("request while disabled"); // R9
  AST_MASK_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && rkind == RK_MASK) |=> (param_o[PARAM_W-1:N_CORE] == '0)) else $error("mask upper bits set"); // R4
endmodule

// File: tb/test_irq_distributor.sv
module test_irq_distributor;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 256;
  localparam int NC = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NI-1:0]  src = '0;
  logic           cmd_we = 1'b0;
  logic [15:0]    cmd = '0;
  logic [1:0]     cmd_core = '0;
  logic           param_we = 1'b0;
  logic [31:0]    param_in = '0;
  logic [31:0]    param_out;
  logic [NC-1:0]  irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_distributor i_irq_distributor (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .src_i      (src),
    .cmd_we_i   (cmd_we),
    .cmd_i      (cmd),
    .cmd_core_i (cmd_core),
    .param_we_i (param_we),
    .param_i    (param_in),
    .param_o    (param_out),
    .irq_o      (irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // all tasks start and end on a falling edge
  task automatic do_cmd(input int num, input int opc, input int core = 0);
    cmd_we   = 1'b1;
    cmd      = {num[7:0], opc[7:0]};
    cmd_core = core[1:0];
    @(negedge clk);
    cmd_we   = 1'b0;
  endtask

  task automatic wp(input logic [31:0] v);
    param_we = 1'b1;
    param_in = v;
    @(negedge clk);
    param_we = 1'b0;
  endtask

  task automatic rd(input int num, input int opc, output logic [31:0] v);
    do_cmd(num, opc);
    v = param_out;
  endtask

  task automatic setup(input int num, input int trig, input int dest, input int mask);
    wp(32'(trig << 15) | 32'(dest));
    do_cmd(num, 8'h04);
    wp(32'(mask));
    do_cmd(num, 8'h09);
  endtask

  function automatic int next_set(input int mask, input int last);
    for (int k = 1; k <= NC; k++) begin
      int j;
      j = (last + k) % NC;
      if (mask[j]) return j;
    end
    return last;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, keep;
    int last, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq_o after reset", 32'(irq), 32'h0);
    rd(5, 8'h08, v);  chk("R1 mode after reset", v, 32'h0);
    rd(5, 8'h0A, v);  chk("R1 mask after reset", v, 32'h0);
    rd(5, 8'h05, v);  chk("R1 status after reset", v, 32'h0);

    // R3 mode sweep over every source, codes above 3 stored as 0
    for (int i = 0; i < NI; i++) begin
      int d;
      d = (i % 5 == 4) ? 9 : (i % 5);
      wp(32'h00F0_0000 | 32'((i & 1) << 15) | 32'(d));
      do_cmd(i, 8'h04);
      rd(i, 8'h08, v);
      chk($sformatf("R3 mode irq %0d", i), v, 32'((i & 1) << 15) | 32'((d > 3) ? 0 : d));
    end

    // R4 mask sweep, upper bits read back 0
    for (int i = 0; i < NI; i++) begin
      wp(32'hFFFF_FFF0 | 32'(i & 15));
      do_cmd(i, 8'h09);
      rd(i, 8'h0A, v);
      chk($sformatf("R4 mask irq %0d", i), v, 32'(i & 15));
    end

    // R2 unknown opcodes change nothing
    rd(7, 8'h08, keep);
    do_cmd(7, 8'h0B);
    chk("R2 opcode 0x0B param_o unchanged", param_out, keep);
    do_cmd(7, 8'hFF);
    chk("R2 opcode 0xFF param_o unchanged", param_out, keep);
    rd(7, 8'h08, v);
    chk("R2 mode intact after unknown opcode", v, keep);

    // R5 pulse capture, sticky, cleared
    setup(10, 1, 2, 0);
    src[10] = 1'b1; tick(); tick();
    rd(10, 8'h07, v); chk("R5 pulse pending set", v, 32'h1);
    src[10] = 1'b0; tick();
    rd(10, 8'h07, v); chk("R5 pulse pending sticky", v, 32'h1);
    do_cmd(10, 8'h02);
    rd(10, 8'h07, v); chk("R5 pending removed by clear", v, 32'h0);

    // R6 level follows the line, masked by destination off
    setup(11, 0, 3, 0);
    src[11] = 1'b1; tick();
    rd(11, 8'h07, v); chk("R6 level pending high", v, 32'h1);
    src[11] = 1'b0; tick();
    rd(11, 8'h07, v); chk("R6 level pending low", v, 32'h0);
    setup(11, 0, 0, 0);
    src[11] = 1'b1; tick();
    rd(11, 8'h07, v); chk("R6 level masked when off", v, 32'h0);
    src[11] = 1'b0;

    // R7 software assert
    setup(12, 0, 3, 0);
    do_cmd(12, 8'h03);
    rd(12, 8'h07, v); chk("R7 assert sets pending", v, 32'h1);
    do_cmd(12, 8'h02);
    rd(12, 8'h07, v); chk("R7 cleared after assert", v, 32'h0);

    // R8 status layout
    setup(13, 0, 1, 0);
    src[13] = 1'b1; tick();
    rd(13, 8'h05, v); chk("R8 status on/raw/pend", v, 32'h0000_000B);
    src[13] = 1'b0; tick();
    rd(13, 8'h05, v); chk("R8 status raw low", v, 32'h0000_0001);

    // R9 capture while disabled, then R12 all-targets acks
    setup(20, 1, 3, 15);
    src[20] = 1'b1; tick(); tick(); tick();
    chk("R9 no request while disabled", 32'(irq), 32'h0);
    rd(20, 8'h07, v); chk("R9 pending captured while disabled", v, 32'h1);
    do_cmd(0, 8'h01);
    chk("R9 request appears on enable", 32'(irq), 32'hF);
    for (int c = 0; c < NC; c++) begin
      do_cmd(20, 8'h06, c);
      chk($sformatf("R12 after ack core %0d", c), 32'(irq), 32'(4'hF & ~((2 << c) - 1)));
    end
    do_cmd(20, 8'h06, 0);
    chk("R12 extra ack no effect", 32'(irq), 32'h0);
    rd(20, 8'h07, v); chk("R12 pending removed by ack", v, 32'h0);
    src[20] = 1'b0; tick(); tick();

    // R10 round-robin over mask 1011
    setup(30, 1, 1, 4'b1011);
    last = 0;
    for (int r = 0; r < 5; r++) begin
      exp = next_set(4'b1011, last);
      do_cmd(30, 8'h03);
      tick();
      chk($sformatf("R13 R10 round %0d recipient", r), 32'(irq), 32'(1 << exp));
      rd(30, 8'h05, v);
      chk($sformatf("R10 round %0d next pointer", r), 32'(v[9:8]), 32'(next_set(4'b1011, exp)));
      do_cmd(30, 8'h06, (exp + 2) % NC);
      chk($sformatf("R12 round %0d wrong-core ack ignored", r), 32'(irq), 32'(1 << exp));
      do_cmd(30, 8'h06, exp);
      chk($sformatf("R13 round %0d ack withdraws", r), 32'(irq), 32'h0);
      tick(); tick();
      last = exp;
    end

    // R11 first taker, level source
    setup(40, 0, 2, 4'b0101);
    src[40] = 1'b1; tick(); tick();
    chk("R11 all targets requested", 32'(irq), 32'h5);
    do_cmd(0, 8'h00);
    chk("R9 global disable drops requests", 32'(irq), 32'h0);
    do_cmd(0, 8'h01);
    chk("R9 re-enable restores requests", 32'(irq), 32'h5);
    do_cmd(40, 8'h06, 1);
    chk("R12 non-target ack ignored", 32'(irq), 32'h5);
    do_cmd(40, 8'h06, 2);
    chk("R11 first ack withdraws all", 32'(irq), 32'h0);
    rd(40, 8'h05, v); chk("R11 status while source high", v, 32'h0000_020F);
    tick(); tick(); tick();
    chk("R11 no redelivery while level high", 32'(irq), 32'h0);
    src[40] = 1'b0; tick(); tick();
    rd(40, 8'h05, v); chk("R11 ack cleared after source low", v, 32'h0000_0201);

    // R5 clear aborts delivery
    setup(50, 1, 3, 4'b0011);
    do_cmd(50, 8'h03);
    tick();
    chk("R5 delivery before clear", 32'(irq), 32'h3);
    do_cmd(50, 8'h02);
    chk("R5 clear withdraws requests", 32'(irq), 32'h0);
    rd(50, 8'h07, v); chk("R5 pending after clear", v, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule